// File: doc/BRIEF.md
# Four-level page table walker with per-level memory-type selection

This block resolves a virtual page number into a physical frame by reading up to four levels of 64-bit paging structures through a memory read port. A request carries the 36-bit virtual page number together with the root frame, the root cache-disable and write-through bits and a context-identifier enable flag, all captured when the request is accepted. The walker then issues one entry read per level, in order: top-level map, pointer table, directory, page table. It stops after three reads when a directory entry maps a 2 MiB page. It accepts a new request only while it is idle.

Every entry read carries a memory-type tag. The tag is looked up in an eight-entry byte-wide attribute table, held in a 64-bit register that software writes through a write-enable port. The index for the top-level read comes from the root bits, or is forced to entry 0 when context identifiers are enabled. The index for each lower read comes from the cache-control bits of the parent entry. The result reports the frame, the page size, the memory type of the final mapping and the level that ended the walk, or a fault.

Top module: `pt_walker`

## Requirements
- R1: Reads are issued in level order 0 (top), 1, 2, 3. Level L uses the 9-bit index at virtual page number bits [35-9L:27-9L]. The entry byte address is frame*4096 + index*8. The port gives line = address>>6 and slot = address[5:3]. A 4 KiB walk makes exactly four reads and ends with level 3 and frame = leaf entry bits [51:12].
- R2: A present level-2 entry with bit 7 set ends the walk after three reads. The result has big=1, level 2, and frame = {entry[51:21], vpn[8:0]}. Bit 7 in a level-3 entry has no such effect.
- R3: With the context flag clear, the level-0 read type is attribute entry 2*PCD+PWT, taken from the root bits.
- R4: With the context flag set, the level-0 read type is attribute entry 0, whatever the root bits are.
- R5: The read at levels 1 to 3 uses attribute entry 2*PCD+PWT, where PCD is bit 4 and PWT is bit 3 of the parent entry. The context flag does not change it.
- R6: After reset the attribute register is 0x0007040600070406, with entry 0 in bits [7:0]. Entries 0 to 3 are therefore 0x06 write-back, 0x04 write-through, 0x07 UC- and 0x00 uncacheable.
- R7: An entry with bit 0 clear ends the walk with fault=1 and the level of that entry, and no further read is made. The frame, type and big outputs are all 0.
- R8: The final type of a successful walk is attribute entry 2*PCD+PWT of the leaf entry.
- R9: req_ready_o is high only while idle. A request made while a walk is in progress is ignored. req_ready_o returns high the cycle after done_o.
- R10: An attribute write affects walks accepted after the write edge. The walk in progress keeps the table it started with.
- R11: In reset, and right after it, req_ready_o=1, mem_req_valid_o=0 and done_o=0.
- R12: While mem_req_valid_o is high and mem_req_ready_i is low, the request stays valid and its line, slot, type and level do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request taken |
| req_vpn_i | input | 36 | Virtual page number |
| root_frame_i | input | PA_W-12 | Frame of the top-level map |
| root_pcd_i | input | 1 | Root cache-disable bit |
| root_pwt_i | input | 1 | Root write-through bit |
| ctx_en_i | input | 1 | Context identifiers enabled |
| attr_we_i | input | 1 | Attribute register write enable |
| attr_wdata_i | input | 64 | Attribute register write data |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_line_o | output | PA_W-6 | 64-byte line address of the entry |
| mem_req_slot_o | output | 3 | Entry slot within the line |
| mem_req_type_o | output | 8 | Memory type of the read |
| mem_req_level_o | output | 2 | Level being read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Entry read back |
| done_o | output | 1 | Result valid, one cycle |
| done_frame_o | output | PA_W-12 | Physical 4 KiB frame number |
| done_big_o | output | 1 | 2 MiB mapping |
| done_type_o | output | 8 | Final memory type |
| done_fault_o | output | 1 | Walk ended on a non-present entry |
| done_level_o | output | 2 | Level that ended the walk |

## Verification
The first read request is raised in the cycle after a request is accepted. Each following read is raised in the cycle after the previous response. done_o rises in the cycle after the last response and lasts one cycle, and req_ready_o returns one cycle later. The bench drives the response port one cycle after each read handshake, with back-pressure that repeats every three cycles. It samples every output at the falling edge and matches each read handshake and each result against queues that a behavioural walk of its own table image fills when the request is issued. Idle status and the hold of stalled requests are compared on every falling edge against the model's state from the edges before.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int PAGE_SH  = 12;
  localparam int LINE_SH  = 6;
  localparam int IDX_W    = 9;
  localparam int LEVELS   = 4;
  localparam int LVL_W    = $clog2(LEVELS);
  localparam int SLOT_W   = IDX_W - (PAGE_SH - LINE_SH);
  localparam int ENTRY_W  = 64;
  localparam int MT_W     = 8;
  localparam int ATTR_N   = 8;
  localparam int ATTR_W   = ATTR_N * MT_W;
  localparam int BIG_SH   = PAGE_SH + IDX_W;

  localparam int PRES_BIT = 0;
  localparam int PWT_BIT  = 3;
  localparam int PCD_BIT  = 4;
  localparam int PS_BIT   = 7;

  localparam logic [LVL_W-1:0] LVL_DIR = LVL_W'(LEVELS - 2);
  localparam logic [LVL_W-1:0] LVL_PT  = LVL_W'(LEVELS - 1);

  localparam logic [MT_W-1:0] MT_UC  = 8'h00;
  localparam logic [MT_W-1:0] MT_WC  = 8'h01;
  localparam logic [MT_W-1:0] MT_WT  = 8'h04;
  localparam logic [MT_W-1:0] MT_WB  = 8'h06;
  localparam logic [MT_W-1:0] MT_UCM = 8'h07;

  localparam logic [ATTR_W-1:0] ATTR_RST =
    {MT_UC, MT_UCM, MT_WT, MT_WB, MT_UC, MT_UCM, MT_WT, MT_WB};

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} walk_st_e;
endpackage

// File: rtl/pt_attr_reg.sv
module pt_attr_reg
  import pt_walker_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ATTR_W-1:0] wdata_i,
  input  logic              snap_i,
  output logic [ATTR_W-1:0] snap_o
);
  logic [ATTR_W-1:0] live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= ATTR_RST;
      snap_o <= ATTR_RST;
    end else begin
      if (we_i) live_q <= wdata_i;
      // walk copy takes the value before a same-edge write
      if (snap_i) snap_o <= live_q;
    end
  end
endmodule

// File: rtl/pt_type_sel.sv
module pt_type_sel
  import pt_walker_pkg::*;
(
  input  logic [ATTR_W-1:0] table_i,
  input  logic              root_i,
  input  logic              ctx_i,
  input  logic              pcd_i,
  input  logic              pwt_i,
  output logic [MT_W-1:0]   type_o
);
  localparam int SEL_W = $clog2(ATTR_N);

  logic [MT_W-1:0]  ent_a [ATTR_N];
  logic [SEL_W-1:0] sel;

  for (genvar i = 0; i < ATTR_N; i++) begin : g_ent
    assign ent_a[i] = table_i[i*MT_W +: MT_W];
  end

  assign sel    = (root_i && ctx_i) ? '0 : SEL_W'({pcd_i, pwt_i});
  assign type_o = ent_a[sel];
endmodule

// File: rtl/pt_idx_sel.sv
module pt_idx_sel
  import pt_walker_pkg::*;
#(
  parameter  int FR_W  = 40,
  localparam int VPN_W = LEVELS * IDX_W,
  localparam int LN_W  = FR_W + IDX_W - SLOT_W
) (
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [FR_W-1:0]   base_i,
  output logic [LN_W-1:0]   line_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [IDX_W-1:0] idx_a [LEVELS];
  logic [IDX_W-1:0] idx;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    assign idx_a[l] = vpn_i[IDX_W*(LEVELS-1-l) +: IDX_W];
  end

  assign idx    = idx_a[level_i];
  assign line_o = {base_i, idx[IDX_W-1:SLOT_W]};
  assign slot_o = idx[SLOT_W-1:0];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter  int PA_W  = 52,
  localparam int FR_W  = PA_W - PAGE_SH,
  localparam int LN_W  = PA_W - LINE_SH,
  localparam int VPN_W = LEVELS * IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VPN_W-1:0]   req_vpn_i,
  input  logic [FR_W-1:0]    root_frame_i,
  input  logic               root_pcd_i,
  input  logic               root_pwt_i,
  input  logic               ctx_en_i,
  input  logic               attr_we_i,
  input  logic [ATTR_W-1:0]  attr_wdata_i,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic [LN_W-1:0]    mem_req_line_o,
  output logic [SLOT_W-1:0]  mem_req_slot_o,
  output logic [MT_W-1:0]    mem_req_type_o,
  output logic [LVL_W-1:0]   mem_req_level_o,
  input  logic               mem_rsp_valid_i,
  input  logic [ENTRY_W-1:0] mem_rsp_data_i,
  output logic               done_o,
  output logic [FR_W-1:0]    done_frame_o,
  output logic               done_big_o,
  output logic [MT_W-1:0]    done_type_o,
  output logic               done_fault_o,
  output logic [LVL_W-1:0]   done_level_o
);
  walk_st_e          st_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [FR_W-1:0]   base_q;
  logic              pcd_q, pwt_q, ctx_q;
  logic [ATTR_W-1:0] attr_snap;
  logic [MT_W-1:0]   leaf_type;
  logic              accept;
  logic              ent_present, ent_big, ent_last;
  logic              unused_ent;

  assign req_ready_o     = (st_q == ST_IDLE);
  assign accept          = req_valid_i && req_ready_o;
  assign mem_req_valid_o = (st_q == ST_REQ);
  assign mem_req_level_o = lvl_q;
  assign done_o          = (st_q == ST_DONE);

  pt_attr_reg u_attr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (attr_we_i),
    .wdata_i (attr_wdata_i),
    .snap_i  (accept),
    .snap_o  (attr_snap)
  );

  pt_idx_sel #(.FR_W(FR_W)) u_idx (
    .vpn_i   (vpn_q),
    .level_i (lvl_q),
    .base_i  (base_q),
    .line_o  (mem_req_line_o),
    .slot_o  (mem_req_slot_o)
  );

  pt_type_sel u_rd_type (
    .table_i (attr_snap),
    .root_i  (lvl_q == '0),
    .ctx_i   (ctx_q),
    .pcd_i   (pcd_q),
    .pwt_i   (pwt_q),
    .type_o  (mem_req_type_o)
  );

  pt_type_sel u_leaf_type (
    .table_i (attr_snap),
    .root_i  (1'b0),
    .ctx_i   (1'b0),
    .pcd_i   (mem_rsp_data_i[PCD_BIT]),
    .pwt_i   (mem_rsp_data_i[PWT_BIT]),
    .type_o  (leaf_type)
  );

  assign ent_present = mem_rsp_data_i[PRES_BIT];
  assign ent_big     = mem_rsp_data_i[PS_BIT] && (lvl_q == LVL_DIR);
  assign ent_last    = (lvl_q == LVL_PT);
  assign unused_ent  = ^{mem_rsp_data_i[ENTRY_W-1:PA_W],
                         mem_rsp_data_i[PAGE_SH-1:PS_BIT+1],
                         mem_rsp_data_i[PS_BIT-1:PCD_BIT+1],
                         mem_rsp_data_i[PWT_BIT-1:PRES_BIT+1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      lvl_q        <= '0;
      vpn_q        <= '0;
      base_q       <= '0;
      pcd_q        <= 1'b0;
      pwt_q        <= 1'b0;
      ctx_q        <= 1'b0;
      done_frame_o <= '0;
      done_big_o   <= 1'b0;
      done_type_o  <= '0;
      done_fault_o <= 1'b0;
      done_level_o <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          vpn_q  <= req_vpn_i;
          base_q <= root_frame_i;
          pcd_q  <= root_pcd_i;
          pwt_q  <= root_pwt_i;
          ctx_q  <= ctx_en_i;
          lvl_q  <= '0;
          st_q   <= ST_REQ;
        end
        ST_REQ: if (mem_req_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (!ent_present) begin
            done_fault_o <= 1'b1;
            done_big_o   <= 1'b0;
            done_frame_o <= '0;
            done_type_o  <= '0;
            done_level_o <= lvl_q;
            st_q         <= ST_DONE;
          end else if (ent_big) begin
            done_fault_o <= 1'b0;
            done_big_o   <= 1'b1;
            done_frame_o <= {mem_rsp_data_i[PA_W-1:BIG_SH], vpn_q[IDX_W-1:0]};
            done_type_o  <= leaf_type;
            done_level_o <= lvl_q;
            st_q         <= ST_DONE;
          end else if (ent_last) begin
            done_fault_o <= 1'b0;
            done_big_o   <= 1'b0;
            done_frame_o <= mem_rsp_data_i[PA_W-1:PAGE_SH];
            done_type_o  <= leaf_type;
            done_level_o <= lvl_q;
            st_q         <= ST_DONE;
          end else begin
            base_q <= mem_rsp_data_i[PA_W-1:PAGE_SH];
            pcd_q  <= mem_rsp_data_i[PCD_BIT];
            pwt_q  <= mem_rsp_data_i[PWT_BIT];
            lvl_q  <= lvl_q + LVL_W'(1);
            st_q   <= ST_REQ;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import pt_walker_pkg::*;
#(
  parameter int FR_W = 40,
  parameter int LN_W = 46
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [LN_W-1:0]   mem_req_line_o,
  input logic [SLOT_W-1:0] mem_req_slot_o,
  input logic [MT_W-1:0]   mem_req_type_o,
  input logic [LVL_W-1:0]  mem_req_level_o,
  input logic              done_o,
  input logic [FR_W-1:0]   done_frame_o,
  input logic              done_big_o,
  input logic [MT_W-1:0]   done_type_o,
  input logic              done_fault_o,
  input logic [LVL_W-1:0]  done_level_o
);
  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o &&
      $stable(mem_req_line_o) && $stable(mem_req_slot_o) &&
      $stable(mem_req_type_o) && $stable(mem_req_level_o));

  // R9
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> req_ready_o && !done_o);

  // R7
  fault_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && done_fault_o |-> !done_big_o && done_type_o == '0 && done_frame_o == '0);

  // R2
  big_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && done_big_o |-> done_level_o == LVL_DIR);

  // R1
  leaf_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !done_fault_o && !done_big_o |-> done_level_o == LVL_PT);
endmodule

bind pt_walker pt_walker_chk #(.FR_W(FR_W), .LN_W(LN_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_ready_o     (req_ready_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_line_o  (mem_req_line_o),
  .mem_req_slot_o  (mem_req_slot_o),
  .mem_req_type_o  (mem_req_type_o),
  .mem_req_level_o (mem_req_level_o),
  .done_o          (done_o),
  .done_frame_o    (done_frame_o),
  .done_big_o      (done_big_o),
  .done_type_o     (done_type_o),
  .done_fault_o    (done_fault_o),
  .done_level_o    (done_level_o)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  import pt_walker_pkg::*;
  localparam int PA_W = 52;
  localparam int FR_W = PA_W - 12;
  localparam int LN_W = PA_W - 6;
  localparam int WD   = 100000;
  localparam int P = 1, PWT = 8, PCD = 16, PS = 128;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [35:0] req_vpn = '0;
  logic [FR_W-1:0] root_frame = '0;
  logic root_pcd = 1'b0, root_pwt = 1'b0, ctx_en = 1'b0;
  logic attr_we = 1'b0;
  logic [63:0] attr_wdata = '0;
  logic mreq_v, mreq_rdy = 1'b0;
  logic [LN_W-1:0] mreq_line;
  logic [2:0] mreq_slot;
  logic [7:0] mreq_type;
  logic [1:0] mreq_lvl;
  logic mrsp_v = 1'b0;
  logic [63:0] mrsp_d = '0;
  logic done;
  logic [FR_W-1:0] d_frame;
  logic d_big, d_fault;
  logic [7:0] d_type;
  logic [1:0] d_lvl;

  pt_walker #(.PA_W(PA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vpn_i(req_vpn),
    .root_frame_i(root_frame), .root_pcd_i(root_pcd), .root_pwt_i(root_pwt),
    .ctx_en_i(ctx_en), .attr_we_i(attr_we), .attr_wdata_i(attr_wdata),
    .mem_req_valid_o(mreq_v), .mem_req_ready_i(mreq_rdy),
    .mem_req_line_o(mreq_line), .mem_req_slot_o(mreq_slot),
    .mem_req_type_o(mreq_type), .mem_req_level_o(mreq_lvl),
    .mem_rsp_valid_i(mrsp_v), .mem_rsp_data_i(mrsp_d),
    .done_o(done), .done_frame_o(d_frame), .done_big_o(d_big),
    .done_type_o(d_type), .done_fault_o(d_fault), .done_level_o(d_lvl)
  );

  typedef struct { longint line; int slot; int mt; int lvl; string tag; } rd_t;
  typedef struct { longint frame; bit big; int mt; bit fault; int lvl; string tag; } dn_t;

  rd_t rq[$];
  dn_t dq[$];
  logic [63:0] mem [longint];
  logic [63:0] attr_m = 64'h0007040600070406;
  int total = 0, bad = 0, cyc = 0;
  bit busy = 0, pend = 0, hold_v = 0;
  longint pend_a = 0, hold_val = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rdm(longint a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic int ix(longint vpn, int l);
    return int'((vpn >> (9*(3-l))) & 511);
  endfunction

  function automatic int mt_of(logic [63:0] t, int i);
    return int'((t >> (8*i)) & 64'hff);
  endfunction

  task automatic put(longint f, int idx, longint fn, int fl);
    mem[f*4096 + longint'(idx)*8] = 64'((fn << 12) | longint'(fl));
  endtask

  task automatic tbl(longint vpn, longint rf, longint f1, longint f2, longint f3,
                     longint leaf, int fl0, int fl1, int fl2, int fl3);
    put(rf, ix(vpn, 0), f1, fl0);
    put(f1, ix(vpn, 1), f2, fl1);
    put(f2, ix(vpn, 2), f3, fl2);
    put(f3, ix(vpn, 3), leaf, fl3);
  endtask

  // behavioural walk of the table image: fills expected reads and result
  task automatic plan(longint vpn, longint rf, bit pcd, bit pwt, bit ctx, string ttag);
    longint base = rf;
    int cp = int'(pcd), cw = int'(pwt);
    logic [63:0] snap = attr_m;
    logic [63:0] e;
    rd_t r;
    dn_t d;
    for (int l = 0; l < 4; l++) begin
      longint a = base*4096 + longint'(ix(vpn, l))*8;
      r.line = a >> 6;
      r.slot = int'((a >> 3) & 7);
      r.mt   = mt_of(snap, (l == 0 && ctx) ? 0 : cp*2 + cw);
      r.lvl  = l;
      r.tag  = (ttag != "") ? ttag : (l == 0 ? (ctx ? "R4" : "R3") : "R5");
      rq.push_back(r);
      e = rdm(a);
      if (!e[0]) begin
        d = '{0, 0, 0, 1, l, "R7"};
        break;
      end
      if (l == 2 && e[7]) begin
        d = '{(longint'(e[51:21]) << 9) | (vpn & 511), 1,
              mt_of(snap, int'(e[4])*2 + int'(e[3])), 0, 2, "R2"};
        break;
      end
      if (l == 3) begin
        d = '{longint'(e[51:12]), 0, mt_of(snap, int'(e[4])*2 + int'(e[3])), 0, 3, "R8"};
        break;
      end
      base = longint'(e[51:12]);
      cp = int'(e[4]);
      cw = int'(e[3]);
    end
    dq.push_back(d);
  endtask

  task automatic start(longint vpn, longint rf, bit pcd, bit pwt, bit ctx);
    @(negedge clk);
    req_valid  = 1'b1;
    req_vpn    = 36'(vpn);
    root_frame = FR_W'(rf);
    root_pcd   = pcd;
    root_pwt   = pwt;
    ctx_en     = ctx;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    busy = 1;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic run(longint vpn, longint rf, bit pcd, bit pwt, bit ctx, string ttag);
    plan(vpn, rf, pcd, pwt, ctx, ttag);
    start(vpn, rf, pcd, pwt, ctx);
    wait_idle();
  endtask

  task automatic wr_attr(logic [63:0] v);
    @(negedge clk);
    attr_we = 1'b1;
    attr_wdata = v;
    @(negedge clk);
    attr_we = 1'b0;
    attr_m = v;
  endtask

  // per-clock monitor, responder and comparison
  always @(negedge clk) begin
    rd_t r;
    dn_t d;
    cyc++;
    if (cyc > WD) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WD);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rst_n) begin
      chk("R9", "req_ready", longint'(req_ready), longint'(!busy));
      if (pend) begin
        mrsp_v = 1'b1;
        mrsp_d = rdm(pend_a);
        pend = 0;
      end else begin
        mrsp_v = 1'b0;
      end
      if (hold_v)
        chk("R12", "stalled request",
            longint'({mreq_v, mreq_line, mreq_slot, mreq_type, mreq_lvl}), hold_val);
      mreq_rdy = (cyc % 3) != 1;
      hold_v = mreq_v && !mreq_rdy;
      hold_val = longint'({mreq_v, mreq_line, mreq_slot, mreq_type, mreq_lvl});
      if (mreq_v && mreq_rdy) begin
        if (rq.size() == 0) begin
          total++;
          bad++;
          $display("FAIL R9 unexpected read act=%0h exp=none", mreq_line);
        end else begin
          r = rq.pop_front();
          chk("R1", "line", longint'(mreq_line), r.line);
          chk("R1", "slot", longint'(mreq_slot), longint'(r.slot));
          chk("R1", "level", longint'(mreq_lvl), longint'(r.lvl));
          chk(r.tag, "read type", longint'(mreq_type), longint'(r.mt));
        end
        pend = 1;
        pend_a = longint'({mreq_line, mreq_slot, 3'b000});
      end
      if (done) begin
        if (dq.size() == 0) begin
          total++;
          bad++;
          $display("FAIL R9 unexpected done act=1 exp=0");
        end else begin
          d = dq.pop_front();
          chk(d.tag, "frame", longint'(d_frame), d.frame);
          chk(d.tag, "big", longint'(d_big), longint'(d.big));
          chk(d.tag, "final type", longint'(d_type), longint'(d.mt));
          chk(d.tag, "fault", longint'(d_fault), longint'(d.fault));
          chk(d.tag, "level", longint'(d_lvl), longint'(d.lvl));
          chk("R1", "reads used", longint'(rq.size()), 0);
        end
        busy = 0;
      end
    end
  end

  initial begin
    longint v1 = 36'h0A53C9F1B;
    longint v2 = 36'h3F0012345;
    longint v3 = 36'h1C0FFEE77;
    longint v4 = 36'h2468ACE13;
    longint v5 = 36'h13579BDF1;
    longint v6 = 36'h0FEDCBA98;
    longint v7 = 36'h305060708;

    repeat (3) @(negedge clk);
    chk("R11", "ready in reset", longint'(req_ready), 1);
    chk("R11", "read valid in reset", longint'(mreq_v), 0);
    chk("R11", "done in reset", longint'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "ready after reset", longint'(req_ready), 1);
    chk("R11", "read valid after reset", longint'(mreq_v), 0);
    chk("R11", "done after reset", longint'(done), 0);

    tbl(v1, 'h100, 'h101, 'h102, 'h103, 'hABCDE, P|PWT, P|PCD, P|PCD|PWT, P);
    tbl(v2, 'h200, 'h201, 'h202, 'h203, 'h55555, P, P, P, P|PCD|PWT);
    tbl(v3, 'h300, 'h301, 'h302, 'h12345, 'h77, P, P|PWT, P|PS|PCD, P);
    tbl(v4, 'h400, 'h401, 'h402, 'h403, 'h11, 0, P, P, P);
    tbl(v5, 'h500, 'h501, 'h502, 'h503, 'h22, P, P, 0, P);
    tbl(v6, 'h600, 'h601, 'h602, 'h603, 'h33333, P, P, P, P|PS|PWT);
    tbl(v7, 'h700, 'h701, 'h702, 'h703, 'h44, P, P|PCD, P, 0);

    // R6 reset table across all four index values
    run(v1, 'h100, 0, 0, 0, "R6");
    // R3 root bits select top-level type
    run(v1, 'h100, 1, 0, 0, "");
    run(v1, 'h100, 1, 1, 0, "");
    run(v1, 'h100, 0, 1, 0, "");
    // R4 context flag forces entry 0 at the top only, R5 below
    run(v1, 'h100, 1, 1, 1, "");
    run(v2, 'h200, 1, 0, 1, "");
    // R8 leaf type
    run(v2, 'h200, 0, 0, 0, "");
    // R2 2 MiB stop at directory; bit 7 at page level is ordinary
    run(v3, 'h300, 0, 1, 0, "");
    run(v6, 'h600, 0, 0, 0, "");
    // R7 faults at levels 0, 2, 3
    run(v4, 'h400, 0, 0, 0, "");
    run(v5, 'h500, 1, 1, 0, "");
    run(v7, 'h700, 0, 0, 1, "");

    // R10 new table applies to later walks
    wr_attr(64'h0000000004060001);
    run(v1, 'h100, 0, 0, 0, "R10");
    // R10 write during a walk leaves it alone
    plan(v1, 'h100, 0, 0, 0, "R10");
    start(v1, 'h100, 0, 0, 0);
    @(negedge clk);
    wr_attr(64'h0007040600070406);
    wait_idle();
    run(v1, 'h100, 0, 0, 0, "R10");

    // R9 request while busy is ignored
    plan(v2, 'h200, 0, 1, 0, "");
    start(v2, 'h200, 0, 1, 0);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b1;
    req_vpn = 36'(v3);
    root_frame = FR_W'('h300);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R9", "no stray read left", longint'(rq.size()), 0);
    chk("R9", "no stray result left", longint'(dq.size()), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule